// File: doc/BRIEF.md
# Transaction In-Flight Table with Hazard CAM

This block sits at the front of a memory controller and holds every memory transaction that is still outstanding, whether it came from a local or a remote processor. Each arriving transaction is compared by address against all live entries at once. A new request that hits an entry for the same address is chained behind the youngest entry for that address and waits for it to finish. A response that hits the issued head of such a chain completes that entry and frees its slot. A request that hits nothing takes the lowest free slot.

Every cycle, issue logic picks one eligible entry and sends it towards one of three shared physical resources. Five transaction classes share these resources through a fixed mapping, and a busy bit for each resource blocks further issue to it until the resource reports that it is free again. The pick is registered and then issued, a two-stage pipeline. While an entry sits in the first stage, that entry and its resource are kept out of the next pick. A rotating pointer spreads the grants over all slots so that every waiting entry is served.

Top module: `txn_track_table`

## Requirements
- R1: After reset, iss_valid is 0, in_ready is 1 and the table is empty.
- R2: An accepted request (in_kind=0) whose address matches no live entry is stored in the lowest-numbered free slot. If its resource is free, it is issued exactly 2 clock edges after the edge that accepted it, with iss_idx, iss_addr and iss_cls taken from that entry.
- R3: The class maps to a resource as follows: classes 0 and 1 go to resource 0, class 2 goes to resource 1, classes 3 and 4 go to resource 2. iss_res always carries the mapped resource.
- R4: A resource is busy from the edge on which an entry issues to it until the edge on which its res_done bit is sampled high. No entry issues to a busy resource. An entry that was blocked only by that resource issues 2 edges after the res_done edge.
- R5: An accepted request whose address matches a live entry is stored with a wait mark behind the youngest entry for that address. It does not issue while that predecessor is still in the table, so entries with the same address issue in arrival order.
- R6: An accepted response (in_kind=1) whose address matches the issued, non-waiting head entry for that address retires that entry and frees its slot. The entry chained directly behind it issues 2 edges later if its resource is free.
- R7: A response whose address matches no live entry, or matches only a head that has not yet issued, has no effect on the table.
- R8: The pick starts searching at the slot just after the last picked slot and wraps around from the highest slot to slot 0.
- R9: At most one entry issues per cycle. An entry issues only once. An entry in the first pipeline stage, and any entry that needs the same resource, is kept out of the next pick.
- R10: in_ready is 0 only when all slots are live. A request is then refused, while a response is still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An incoming transaction is present |
| in_kind | input | 1 | 0 = request, 1 = response |
| in_addr | input | AW | Transaction address, used as the CAM key |
| in_cls | input | 3 | Transaction class, 0 to 4 |
| in_ready | output | 1 | The transaction is accepted on this edge |
| res_done | input | 3 | One pulse bit for each resource; the resource is free again |
| iss_valid | output | 1 | An entry issues this cycle |
| iss_idx | output | $clog2(N) | Slot number of the issued entry |
| iss_res | output | 2 | Resource the issued entry goes to |
| iss_cls | output | 3 | Class of the issued entry |
| iss_addr | output | AW | Address of the issued entry |

## Verification
A corrupt wait mark or a wrong chain link shows up as an out-of-order issue for one address, or as an entry that never issues. The bench sees this within a few cycles of the response that should have released the entry. A stuck or wrongly indexed busy bit turns into a missing or early issue exactly 2 edges after a res_done pulse. A faulty free-slot or pointer state appears as an unexpected iss_idx on the next issue. Back-pressure errors show on in_ready in the same cycle that the table becomes full or frees a slot.

// File: rtl/txn_track_table.sv
module txn_track_table #(
  parameter int N  = 32,
  parameter int AW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_kind,
  input  logic [AW-1:0]        in_addr,
  input  logic [2:0]           in_cls,
  output logic                 in_ready,
  input  logic [2:0]           res_done,
  output logic                 iss_valid,
  output logic [$clog2(N)-1:0] iss_idx,
  output logic [1:0]           iss_res,
  output logic [2:0]           iss_cls,
  output logic [AW-1:0]        iss_addr
);
  localparam int IW = $clog2(N);

  function automatic logic [1:0] res_of(input logic [2:0] c);
    case (c)
      3'd0, 3'd1: res_of = 2'd0;
      3'd2:       res_of = 2'd1;
      default:    res_of = 2'd2;
    endcase
  endfunction

  logic [N-1:0]  v_q, w_q, is_q, tl_q;
  logic [AW-1:0] a_q [N];
  logic [2:0]    c_q [N];
  logic [IW-1:0] d_q [N];
  logic [2:0]    busy_q;
  logic          s1_v;
  logic [IW-1:0] s1_idx;
  logic [1:0]    s1_res;
  logic [IW-1:0] ptr_q;

  logic [N-1:0]  hit, elig;
  logic [IW-1:0] free_idx, tail_idx, head_idx, pick_idx;
  logic          tail_hit, head_hit, pick_v;

  for (genvar i = 0; i < N; i++) begin : g_ent
    assign hit[i]  = v_q[i] && (a_q[i] == in_addr);
    assign elig[i] = v_q[i] & ~w_q[i] & ~is_q[i] & ~busy_q[res_of(c_q[i])]
                   & ~(s1_v & ((s1_idx == IW'(i)) | (res_of(c_q[i]) == s1_res)));
  end

  always_comb begin
    free_idx = '0;
    tail_idx = '0; tail_hit = 1'b0;
    head_idx = '0; head_hit = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!v_q[i]) free_idx = IW'(i);
      if (hit[i] && tl_q[i]) begin tail_idx = IW'(i); tail_hit = 1'b1; end
      if (hit[i] && !w_q[i] && is_q[i]) begin head_idx = IW'(i); head_hit = 1'b1; end
    end
  end

  always_comb begin
    pick_v   = 1'b0;
    pick_idx = '0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = (int'(ptr_q) + k) % N;
      if (!pick_v && elig[j]) begin
        pick_v   = 1'b1;
        pick_idx = IW'(j);
      end
    end
  end

  assign in_ready = in_kind | ~(&v_q);

  wire acc      = in_valid & in_ready;
  wire do_alloc = acc & ~in_kind;
  wire do_ser   = do_alloc & tail_hit;
  wire do_merge = acc & in_kind & head_hit;

  always_ff @(posedge clk) begin
    if (do_alloc) begin
      a_q[free_idx] <= in_addr;
      c_q[free_idx] <= in_cls;
      d_q[free_idx] <= tail_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= '0; w_q <= '0; is_q <= '0; tl_q <= '0;
      busy_q <= '0;
      s1_v <= 1'b0; s1_idx <= '0; s1_res <= '0;
      ptr_q <= '0;
      iss_valid <= 1'b0; iss_idx <= '0; iss_res <= '0; iss_cls <= '0; iss_addr <= '0;
    end else begin
      if (do_merge) begin
        v_q[head_idx] <= 1'b0;
        for (int j = 0; j < N; j++)
          if (v_q[j] && w_q[j] && d_q[j] == head_idx) w_q[j] <= 1'b0;
      end
      if (do_alloc) begin
        v_q[free_idx]  <= 1'b1;
        is_q[free_idx] <= 1'b0;
        tl_q[free_idx] <= 1'b1;
        w_q[free_idx]  <= do_ser;
        if (do_ser) tl_q[tail_idx] <= 1'b0;
      end
      s1_v   <= pick_v;
      s1_idx <= pick_idx;
      s1_res <= res_of(c_q[pick_idx]);
      if (pick_v) ptr_q <= (pick_idx == IW'(N - 1)) ? '0 : pick_idx + 1'b1;
      iss_valid <= s1_v;
      if (s1_v) begin
        iss_idx      <= s1_idx;
        iss_res      <= s1_res;
        iss_cls      <= c_q[s1_idx];
        iss_addr     <= a_q[s1_idx];
        is_q[s1_idx] <= 1'b1;
      end
      for (int r = 0; r < 3; r++) begin
        if (s1_v && s1_res == 2'(r)) busy_q[r] <= 1'b1;
        else if (res_done[r])        busy_q[r] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/txn_track_table_chk.sv
module txn_track_table_chk #(
  parameter int N  = 32,
  parameter int IW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_kind,
  input logic          in_ready,
  input logic          iss_valid,
  input logic [IW-1:0] iss_idx,
  input logic [1:0]    iss_res,
  input logic [2:0]    iss_cls,
  input logic [N-1:0]  v_q,
  input logic [N-1:0]  w_q
);
  a_r9_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |=> !(iss_valid && iss_idx == $past(iss_idx)));

  a_r4_res_gap: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |=> !(iss_valid && iss_res == $past(iss_res)));

  a_r3_class_map: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> iss_res == ((iss_cls < 3'd2) ? 2'd0 : (iss_cls == 3'd2) ? 2'd1 : 2'd2));

  a_r10_refuse_full: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |-> (&v_q && !in_kind));

  a_r5_no_waiting_issue: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> !w_q[iss_idx]);
endmodule

bind txn_track_table txn_track_table_chk #(.N(N), .IW($clog2(N))) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
  .in_ready(in_ready), .iss_valid(iss_valid), .iss_idx(iss_idx),
  .iss_res(iss_res), .iss_cls(iss_cls), .v_q(v_q), .w_q(w_q)
);

// File: tb/sim_txn_track_table.sv
module sim_txn_track_table;
  localparam int N = 8, AW = 8, IW = 3;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_kind = 0;
  logic [AW-1:0] in_addr = '0;
  logic [2:0] in_cls = '0, res_done = '0;
  logic in_ready, iss_valid;
  logic [IW-1:0] iss_idx;
  logic [1:0] iss_res;
  logic [2:0] iss_cls;
  logic [AW-1:0] iss_addr;

  int total = 0, bad = 0, cyc = 0, nlog = 0, base = 0, t = 0;
  int lg_idx [64], lg_res [64], lg_cls [64], lg_addr [64], lg_cyc [64];

  always #5 clk = ~clk;

  txn_track_table #(.N(N), .AW(AW)) u0 (.*);

  always @(posedge clk) begin
    cyc = cyc + 1;
    #3;
    if (rst_n && iss_valid && nlog < 64) begin
      lg_idx[nlog] = iss_idx; lg_res[nlog] = iss_res; lg_cls[nlog] = iss_cls;
      lg_addr[nlog] = iss_addr; lg_cyc[nlog] = cyc;
      nlog = nlog + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; tick(2); rst_n = 1; base = nlog; tick(1);
  endtask

  task automatic send(input logic k, input int a, input int c);
    in_valid = 1; in_kind = k; in_addr = AW'(a); in_cls = 3'(c);
    @(negedge clk);
    in_valid = 0; in_kind = 0;
    t = cyc;
  endtask

  task automatic done(input int r);
    res_done = 3'(1 << r);
    @(negedge clk);
    res_done = '0;
    t = cyc;
  endtask

  function automatic int map_res(input int c);
    return (c < 2) ? 0 : (c == 2) ? 1 : 2;
  endfunction

  function automatic int cnt();
    return nlog - base;
  endfunction

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int ts;
    do_reset();
    chk("R1 iss_valid after reset", int'(iss_valid), 0);
    chk("R1 in_ready after reset", int'(in_ready), 1);

    // R2 / R4 basic issue and scoreboard
    send(0, 'h11, 0); ts = t; tick(4);
    chk("R2 one issue", cnt(), 1);
    chk("R2 slot", lg_idx[base], 0);
    chk("R2 addr", lg_addr[base], 'h11);
    chk("R2 cls", lg_cls[base], 0);
    chk("R2 latency", lg_cyc[base], ts + 2);
    send(0, 'h22, 1); tick(6);
    chk("R4 blocked while busy", cnt(), 1);
    done(0); ts = t; tick(4);
    chk("R4 issue after done", cnt(), 2);
    chk("R4 slot", lg_idx[base+1], 1);
    chk("R4 latency after done", lg_cyc[base+1], ts + 2);

    // R3 class sweep
    do_reset();
    for (int c = 0; c < 5; c++) begin
      send(0, 'h30 + c, c); tick(4);
      chk("R3 issued", cnt(), c + 1);
      chk("R3 resource", lg_res[nlog-1], map_res(c));
      chk("R2 lowest free slot", lg_idx[nlog-1], c);
      done(map_res(c));
    end

    // R5 / R6 serialize chain
    do_reset();
    send(0, 'h55, 2); send(0, 'h55, 2); send(0, 'h55, 2);
    done(1); tick(6);
    chk("R5 chained entries wait", cnt(), 1);
    send(1, 'h55, 0); ts = t; tick(4);
    chk("R6 merge releases next", cnt(), 2);
    chk("R5 arrival order", lg_idx[base+1], 1);
    chk("R6 latency", lg_cyc[base+1], ts + 2);
    send(1, 'h55, 0); tick(6);
    chk("R4 third blocked on busy", cnt(), 2);
    done(1); tick(4);
    chk("R5 third issues", cnt(), 3);
    chk("R5 third slot", lg_idx[base+2], 2);
    send(0, 'h66, 0); tick(4);
    chk("R6 freed slot reused", lg_idx[nlog-1], 0);

    // R7 ignored responses
    do_reset();
    send(0, 'h70, 0); send(0, 'h71, 0);
    send(1, 'h71, 0); send(1, 'h99, 0);
    done(0); tick(4);
    chk("R7 unissued head kept", cnt(), 2);
    chk("R7 kept addr", lg_addr[base+1], 'h71);
    send(0, 'h99, 3); ts = t; tick(4);
    chk("R7 no stale entry", cnt(), 3);
    chk("R7 not serialized", lg_cyc[base+2], ts + 2);
    chk("R7 slot", lg_idx[base+2], 2);

    // R8 rotating priority
    do_reset();
    send(0, 'h80, 0); tick(4);
    send(1, 'h80, 0);
    send(0, 'h81, 0); send(0, 'h82, 0);
    done(0); tick(4);
    chk("R8 pointer slot first", lg_idx[nlog-1], 1);
    chk("R8 pointer addr", lg_addr[nlog-1], 'h82);
    done(0); tick(4);
    chk("R8 wrap slot", lg_idx[nlog-1], 0);
    chk("R8 wrap addr", lg_addr[nlog-1], 'h81);

    // R9 pipeline masking with two ready entries
    do_reset();
    send(0, 'h90, 0); send(0, 'h91, 3); tick(4);
    send(0, 'h92, 0); send(0, 'h93, 4); tick(4);
    chk("R9 blocked pair", cnt(), 2);
    res_done = 3'b101; @(negedge clk); res_done = '0; ts = cyc; tick(6);
    chk("R9 both issued once", cnt(), 4);
    chk("R9 first slot", lg_idx[base+2], 2);
    chk("R9 first cycle", lg_cyc[base+2], ts + 2);
    chk("R9 second slot", lg_idx[base+3], 3);
    chk("R9 second cycle", lg_cyc[base+3], ts + 3);

    // R10 full table
    do_reset();
    for (int k = 0; k < N; k++) send(0, 'hA0 + k, 0);
    chk("R10 full not ready", int'(in_ready), 0);
    in_valid = 1; in_kind = 0; in_addr = 'hB0; #1;
    chk("R10 request refused", int'(in_ready), 0);
    @(negedge clk); in_valid = 0;
    in_kind = 1; #1;
    chk("R10 response ready when full", int'(in_ready), 1);
    in_kind = 0;
    send(1, 'hA0, 0);
    chk("R10 ready after free", int'(in_ready), 1);
    send(0, 'hC0, 0);
    chk("R10 full again", int'(in_ready), 0);
    tick(2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule